// File: doc/BRIEF.md
# Branch Sample Record Buffer

This block records taken branches for sampling profilers. While its sampling enable is set, every branch-retired strobe stores the branch source and target addresses into the next slot of a 16-slot register file. It makes one pass from slot 0 to the last slot. When the last slot is written, the write offset returns to 0, the enable clears itself and recording stops. Software then reads the pairs through a small register port. The source register and target register of each slot sit at adjacent addresses.

A configuration and status word holds the enable, a valid-branches flag, the next-write offset and a counter-select field. While sampling is on, a counter-overflow interrupt request is held back. It is delivered one cycle after the enable drops, whether software cleared the enable or the buffer filled up. Software can also write any slot directly. This lets it plant a marker value that shows where its own data ends.

Top module: `branch_record_buf`

## Requirements
- R1: After reset the configuration word reads 0x18 and `irq_out` is 0. In that value the enable, flag, offset and select fields are all zero, and bits 4:3 read as 11b.
- R2: The configuration word is at address 0x10 and has this layout. Bit 2 is the enable and bit 5 is the valid-branches flag. Bits 19:16 hold the next-write offset and bits 26:24 hold the counter select. Bits 4:3 always read 1, and every other bit reads 0.
- R3: While the enable is set, a `br_valid` strobe stores `br_src` at address 0x20+2*offset and `br_dst` at 0x20+2*offset+1. The same strobe advances the offset by one and sets the flag.
- R4: A strobe that writes slot 15 sets the offset to 0 and clears the enable. Later strobes record nothing until software sets the enable again.
- R5: A strobe while the enable is 0 is ignored. The offset, the flag and all slots keep their values.
- R6: A rising `ovf_req` sets a pending request. `irq_out` pulses for one cycle only in the cycle after a clock edge at which the request was pending and the enable was 0. It stays 0 while sampling is enabled.
- R7: A configuration write loads the enable, flag, offset and select fields from the written data. Writing 0 clears them all. Writing back the offset and flag with the enable at 0 keeps them.
- R8: Software writes to any slot register are stored verbatim, including the marker 0xFFFFFFFFFFFFFFFE.
- R9: A recorded branch wins over a software write to the same slot in the same cycle. A configuration write wins over the full-buffer auto-clear in the same cycle.
- R10: `rdata` shows the register at `reg_addr` one cycle after the address is presented. Addresses other than 0x10 and 0x20..0x3F read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch-retired strobe |
| br_src | input | 64 | Branch source address |
| br_dst | input | 64 | Branch target address |
| ovf_req | input | 1 | Counter-overflow interrupt request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 64 | Register write data |
| rdata | output | 64 | Read data, one cycle after the address |
| irq_out | output | 1 | Delivered overflow interrupt pulse |

## Verification
The assertions assume that `rst` is held for at least one clock. They also assume that `reg_addr` and the write strobe stay stable across each clock edge, so a configuration write and a branch strobe are judged by the values present at that edge. The bench drives every input on the falling edge and samples half a cycle or one cycle later. It never reads a slot in the same cycle that slot is being written, because that read returns the old value. Slots are written before they are read, since slot storage has no reset value.

// File: rtl/brb_pkg.sv
package brb_pkg;
  localparam int DATA_W  = 64;
  localparam int EN_BIT  = 2;
  localparam int RSV_LSB = 3;
  localparam int VB_BIT  = 5;
  localparam int OFF_LSB = 16;
  localparam int SEL_LSB = 24;

  function automatic logic [DATA_W-1:0] pack_cfg(input logic en, input logic vb,
                                                  input logic [7:0] off, input logic [7:0] sel);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EN_BIT]              = en;
    w[RSV_LSB +: 2]        = 2'b11;
    w[VB_BIT]              = vb;
    w[OFF_LSB +: 4]        = off[3:0];
    w[SEL_LSB +: 3]        = sel[2:0];
    return w;
  endfunction
endpackage

// File: rtl/brb_cfg_reg.sv
module brb_cfg_reg #(
  parameter int DEPTH = 16,
  parameter int OFF_W = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             wr_en,
  input  logic             wr_vb,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             br_valid,
  output logic             en,
  output logic             vb,
  output logic [OFF_W-1:0] off,
  output logic [SEL_W-1:0] sel
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      vb  <= 1'b0;
      off <= '0;
      sel <= '0;
    end else if (wr) begin
      en  <= wr_en;
      vb  <= wr_vb;
      off <= wr_off;
      sel <= wr_sel;
    end else if (en && br_valid) begin
      vb  <= 1'b1;
      off <= (off == LAST) ? '0 : off + 1'b1;
      en  <= (off != LAST);
    end
  end
endmodule

// File: rtl/brb_entry_store.sv
module brb_entry_store #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rec,
  input  logic [IDX_W-1:0]  rec_idx,
  input  logic [DATA_W-1:0] rec_src,
  input  logic [DATA_W-1:0] rec_dst,
  input  logic              sw_we,
  input  logic              sw_is_dst,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [DATA_W-1:0] sw_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] src_q,
  output logic [DATA_W-1:0] dst_q
);
  logic [DATA_W-1:0] src_mem [DEPTH];
  logic [DATA_W-1:0] dst_mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rec && rec_idx == IDX_W'(i)) begin
        src_mem[i] <= rec_src;
        dst_mem[i] <= rec_dst;
      end else if (sw_we && sw_idx == IDX_W'(i)) begin
        if (sw_is_dst) dst_mem[i] <= sw_data;
        else           src_mem[i] <= sw_data;
      end
    end
    src_q <= src_mem[rd_idx];
    dst_q <= dst_mem[rd_idx];
  end
endmodule

// File: rtl/brb_irq_hold.sv
module brb_irq_hold (
  input  logic clk,
  input  logic rst,
  input  logic ovf_req,
  input  logic en,
  output logic irq_out
);
  logic pend;
  logic fire;

  assign fire = pend && !en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      pend    <= (pend && !fire) || ovf_req;
      irq_out <= fire;
    end
  end
endmodule

// File: rtl/branch_record_buf.sv
module branch_record_buf #(
  parameter int DEPTH      = 16,
  parameter int SEL_W      = 3,
  parameter int ADDR_W     = 8,
  parameter int CFG_ADDR   = 16,
  parameter int ENTRY_BASE = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       br_valid,
  input  logic [brb_pkg::DATA_W-1:0] br_src,
  input  logic [brb_pkg::DATA_W-1:0] br_dst,
  input  logic                       ovf_req,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [brb_pkg::DATA_W-1:0] reg_wdata,
  output logic [brb_pkg::DATA_W-1:0] rdata,
  output logic                       irq_out
);
  import brb_pkg::*;
  localparam int OFF_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(ENTRY_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(ENTRY_BASE + 2 * DEPTH);

  logic             cfg_en, cfg_vb;
  logic [OFF_W-1:0] cfg_off;
  logic [SEL_W-1:0] cfg_sel;

  logic              cfg_hit, ent_hit;
  logic [ADDR_W-1:0] rel;
  logic [OFF_W-1:0]  ent_idx;
  logic              rec;
  logic [DATA_W-1:0] src_q, dst_q;
  logic              rd_cfg_q, rd_ent_q, rd_dst_q;
  logic [DATA_W-1:0] cfg_snap_q;

  assign cfg_hit = (reg_addr == CFG_A);
  assign ent_hit = (reg_addr >= BASE_A) && (reg_addr < END_A);
  assign rel     = reg_addr - BASE_A;
  assign ent_idx = OFF_W'(rel >> 1);
  assign rec     = cfg_en && br_valid;

  brb_cfg_reg #(.DEPTH(DEPTH), .OFF_W(OFF_W), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst),
    .wr(reg_we && cfg_hit),
    .wr_en(reg_wdata[EN_BIT]),
    .wr_vb(reg_wdata[VB_BIT]),
    .wr_off(reg_wdata[OFF_LSB +: OFF_W]),
    .wr_sel(reg_wdata[SEL_LSB +: SEL_W]),
    .br_valid(br_valid),
    .en(cfg_en), .vb(cfg_vb), .off(cfg_off), .sel(cfg_sel)
  );

  brb_entry_store #(.DEPTH(DEPTH), .IDX_W(OFF_W), .DATA_W(DATA_W)) u_store (
    .clk(clk),
    .rec(rec), .rec_idx(cfg_off), .rec_src(br_src), .rec_dst(br_dst),
    .sw_we(reg_we && ent_hit), .sw_is_dst(rel[0]), .sw_idx(ent_idx),
    .sw_data(reg_wdata),
    .rd_idx(ent_idx),
    .src_q(src_q), .dst_q(dst_q)
  );

  brb_irq_hold u_irq (
    .clk(clk), .rst(rst), .ovf_req(ovf_req), .en(cfg_en), .irq_out(irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cfg_q   <= 1'b0;
      rd_ent_q   <= 1'b0;
      rd_dst_q   <= 1'b0;
      cfg_snap_q <= '0;
    end else begin
      rd_cfg_q   <= cfg_hit;
      rd_ent_q   <= ent_hit;
      rd_dst_q   <= rel[0];
      cfg_snap_q <= pack_cfg(cfg_en, cfg_vb, 8'(cfg_off), 8'(cfg_sel));
    end
  end

  always_comb begin
    if (rd_cfg_q)      rdata = cfg_snap_q;
    else if (rd_ent_q) rdata = rd_dst_q ? dst_q : src_q;
    else               rdata = '0;
  end
endmodule

// File: rtl/brb_checker.sv
module brb_checker #(
  parameter int DEPTH      = 16,
  parameter int OFF_W      = 4,
  parameter int ADDR_W     = 8,
  parameter int CFG_ADDR   = 16,
  parameter int ENTRY_BASE = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              br_valid,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [63:0]       rdata,
  input logic              irq_out,
  input logic              en,
  input logic              vb,
  input logic [OFF_W-1:0]  off
);
  logic cfg_wr, mapped;
  assign cfg_wr = reg_we && (int'(reg_addr) == CFG_ADDR);
  assign mapped = (int'(reg_addr) == CFG_ADDR) ||
                  (int'(reg_addr) >= ENTRY_BASE && int'(reg_addr) < ENTRY_BASE + 2 * DEPTH);

  // R3: a recorded branch advances the offset and sets the flag
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (en && br_valid && !cfg_wr) |=> (vb && off == OFF_W'($past(off) + 1)));

  // R4: writing the final slot stops recording and rewinds the offset
  a_r4_autostop: assert property (@(posedge clk) disable iff (rst)
    (en && br_valid && !cfg_wr && off == OFF_W'(DEPTH - 1)) |=> (!en && off == '0));

  // R5: strobes while disabled change nothing
  a_r5_ignored: assert property (@(posedge clk) disable iff (rst)
    (!en && br_valid && !cfg_wr) |=> ($stable(off) && $stable(vb) && !en));

  // R6: interrupt only delivered when sampling was off one cycle earlier
  a_r6_held: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> !$past(en));

  // R6: delivery is a single-cycle pulse
  a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_out |=> !irq_out);

  // R10: unmapped addresses read zero
  a_r10_unmapped: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (rdata == 64'd0));
endmodule

bind branch_record_buf brb_checker #(
  .DEPTH(DEPTH), .OFF_W($clog2(DEPTH)), .ADDR_W(ADDR_W),
  .CFG_ADDR(CFG_ADDR), .ENTRY_BASE(ENTRY_BASE)
) u_chk (
  .clk(clk), .rst(rst), .br_valid(br_valid), .reg_we(reg_we),
  .reg_addr(reg_addr), .rdata(rdata), .irq_out(irq_out),
  .en(cfg_en), .vb(cfg_vb), .off(cfg_off)
);

// File: tb/sim_branch_record_buf.sv
`timescale 1ns/1ps
module sim_branch_record_buf;
  localparam logic [7:0] CFG  = 8'h10;
  localparam logic [7:0] BASE = 8'h20;
  localparam logic [63:0] MARK = 64'hFFFF_FFFF_FFFF_FFFE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_valid = 1'b0;
  logic [63:0] br_src = '0, br_dst = '0;
  logic        ovf_req = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [63:0] reg_wdata = '0;
  logic [63:0] rdata;
  logic        irq_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic rd_issue = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  branch_record_buf u0 (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_src(br_src), .br_dst(br_dst),
    .ovf_req(ovf_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rdata(rdata), .irq_out(irq_out)
  );

  // monitor: read result appears after the edge that captured the address
  always @(posedge clk) begin
    if (rd_issue) begin
      logic [63:0] e;
      string t;
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string t);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] e, input string t);
    @(negedge clk);
    reg_addr = a; rd_issue = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_issue = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h00;
  endtask

  task automatic br(input logic [63:0] s, input logic [63:0] d);
    @(negedge clk);
    br_valid = 1'b1; br_src = s; br_dst = d;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic pulse_ovf();
    @(negedge clk);
    ovf_req = 1'b1;
    @(negedge clk);
    ovf_req = 1'b0;
  endtask

  function automatic logic [63:0] cw(input bit en, input bit vb, input int off, input int sel);
    return 64'h18 | (64'(en) << 2) | (64'(vb) << 5) | (64'(off) << 16) | (64'(sel) << 24);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(64'(irq_out), 64'd0, "R1 irq after reset");
    rd(CFG, 64'h18, "R1 cfg after reset");

    // R3 record three branches
    wr(CFG, 64'h4);
    for (int i = 0; i < 3; i++) br(64'h1000 + 64'(i), 64'h2000 + 64'(i));
    rd(CFG, cw(1, 1, 3, 0), "R3 cfg after 3 branches");
    rd(BASE + 8'd0, 64'h1000, "R3 slot0 src");
    rd(BASE + 8'd1, 64'h2000, "R3 slot0 dst");
    rd(BASE + 8'd5, 64'h2002, "R3 slot2 dst");

    // R7 clear only enable, keep offset and flag
    wr(CFG, cw(0, 1, 3, 0));
    rd(CFG, cw(0, 1, 3, 0), "R7 enable-only clear keeps state");

    // R5 strobe while disabled
    wr(BASE + 8'd6, 64'hAAAA);
    br(64'h5555, 64'h6666);
    rd(BASE + 8'd6, 64'hAAAA, "R5 slot untouched while disabled");
    rd(CFG, cw(0, 1, 3, 0), "R5 cfg untouched while disabled");

    // R8 marker write
    wr(BASE + 8'd11, MARK);
    rd(BASE + 8'd11, MARK, "R8 marker stored");

    // R2 select field, reserved bits
    wr(CFG, 64'hFFFF_0000_F000_0000 | (64'd5 << 24));
    rd(CFG, cw(0, 0, 0, 5), "R2 select field and reserved zero");

    // R7 write zero clears all
    wr(CFG, 64'h0);
    rd(CFG, 64'h18, "R7 zero write clears");

    // R4/R6 full pass with held interrupt
    wr(CFG, 64'h4);
    pulse_ovf();
    chk(64'(irq_out), 64'd0, "R6 held while enabled");
    for (int i = 0; i < 15; i++) br(64'h1000 + 64'(i), 64'h2000 + 64'(i));
    chk(64'(irq_out), 64'd0, "R6 still held before full");
    br(64'h100F, 64'h200F);
    chk(64'(irq_out), 64'd0, "R6 no irq on full edge");
    @(negedge clk);
    chk(64'(irq_out), 64'd1, "R6 irq after auto-clear");
    @(negedge clk);
    chk(64'(irq_out), 64'd0, "R6 single pulse");
    rd(CFG, cw(0, 1, 0, 0), "R4 auto-stop cfg");
    rd(BASE + 8'd30, 64'h100F, "R4 last slot src");
    br(64'h9999, 64'h9999);
    rd(CFG, cw(0, 1, 0, 0), "R4 no record after full");
    rd(BASE + 8'd0, 64'h1000, "R4 slot0 not overwritten");

    // R6 release by software clear
    wr(CFG, 64'h4);
    pulse_ovf();
    chk(64'(irq_out), 64'd0, "R6 held before sw clear");
    wr(CFG, 64'h0);
    chk(64'(irq_out), 64'd0, "R6 no irq on clear edge");
    @(negedge clk);
    chk(64'(irq_out), 64'd1, "R6 irq after sw clear");

    // R6 request while already disabled
    pulse_ovf();
    chk(64'(irq_out), 64'd0, "R6 disabled request latency");
    @(negedge clk);
    chk(64'(irq_out), 64'd1, "R6 disabled request delivered");

    // R9 branch vs software write on same slot
    wr(CFG, cw(1, 0, 4, 0));
    @(negedge clk);
    br_valid = 1'b1; br_src = 64'hB0B; br_dst = 64'hC0C;
    reg_we = 1'b1; reg_addr = BASE + 8'd8; reg_wdata = 64'hDEAD;
    @(negedge clk);
    br_valid = 1'b0; reg_we = 1'b0; reg_addr = 8'h00;
    rd(BASE + 8'd8, 64'hB0B, "R9 branch wins slot write");
    rd(CFG, cw(1, 1, 5, 0), "R9 cfg after collision");

    // R9 cfg write vs auto-clear
    wr(CFG, cw(1, 0, 15, 0));
    @(negedge clk);
    br_valid = 1'b1; br_src = 64'hE0E; br_dst = 64'hF0F;
    reg_we = 1'b1; reg_addr = CFG; reg_wdata = cw(1, 0, 7, 0);
    @(negedge clk);
    br_valid = 1'b0; reg_we = 1'b0; reg_addr = 8'h00;
    rd(CFG, cw(1, 0, 7, 0), "R9 cfg write beats auto-clear");
    wr(CFG, 64'h0);
    rd(BASE + 8'd31, 64'hF0F, "R9 branch still stored");

    // R10 unmapped reads
    rd(8'h05, 64'd0, "R10 unmapped low");
    rd(8'h40, 64'd0, "R10 unmapped past slots");
    rd(8'hFF, 64'd0, "R10 unmapped top");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule